// File: doc/BRIEF.md
# Auto-Increment Word Program Sequencer

This block is the command sequencer of an SPI flash slave for streaming program data. It sees the serial link as four pins: serial clock, active-low select, data in and data out. It uses SPI mode 0 or 3, sampling on the rising serial clock edge with the most significant bit first. The block brings those pins into its own system clock domain and assembles bytes. It decodes a small command set and issues two-byte program requests to a memory port. A counter stands in for the memory's program time and sets the busy flag.

A sequence opens with an entry that carries the start address and one word. After that, each entry carries only a word, and the address moves up by two on its own. The sequence closes on write disable. It also closes by itself when the next word would reach the protected region, which starts at `PROT_BASE`. The host can learn when a write has finished in two ways. It can poll a status byte, or it can switch the data-out pin into a live ready/busy signal.

Top module: `aai_word_seq`

## Requirements
- R1: With the write latch set, a frame of opcode 0xAD, three address bytes (MSB first) and two data bytes issues one request. The request's `prog_addr_o` is the address with bit 0 forced to 0. Its `prog_data_o[15:8]` is the first data byte and `[7:0]` is the second. The mode flag is set.
- R2: While the mode is active, a frame of 0xAD and two data bytes issues a request at the previous request address plus 2.
- R3: An opening 0xAD frame sent while the write latch is clear issues no request and leaves the mode flag clear.
- R4: Opcode 0x06 sets the write latch when the mode is inactive. Opcode 0x04 clears both the write latch and the mode flag.
- R5: Busy holds for `BUSY_CYC` system clocks, starting the clock after each request. A frame that ends while busy is high has no effect.
- R6: After opcode 0x70, while select is low and either the mode or busy is active, `so_oe_o` is 1 and `so_o` is the inverse of busy. Raising select releases the pin. Opcode 0x80 sent outside the mode turns this off.
- R7: While the mode is active, only 0xAD and 0x04 are accepted. A status read (0x05) is also accepted when the live busy output is off. Any other opcode, such as 0x70 or 0x80, is ignored.
- R8: A word whose successor would touch an address at or above `PROT_BASE` is the last one. Issuing it clears the mode flag and the write latch. A further 0xAD frame issues nothing.
- R9: An opening 0xAD frame whose word overlaps `PROT_BASE` or above is ignored.
- R10: If select rises while a byte is only partly shifted in, the frame has no effect.
- R11: Opcode 0x05 returns the status byte on `so_o`, changing on the falling serial clock edge, MSB first, and repeating for as long as select stays low. Bit 0 is busy, bit 1 is the write latch, bit 6 is the mode flag, and all other bits are 0.
- R12: After reset the status byte is 0x00, no request is issued and `so_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from the host |
| csn_i | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out value |
| so_oe_o | output | 1 | Output enable for so_o (0 means high impedance) |
| prog_req_o | output | 1 | One-clock program request pulse |
| prog_addr_o | output | AW | Even byte address of the word |
| prog_data_o | output | 16 | Word data: [15:8] to the even address, [7:0] to the odd address |

## Verification
Two things can happen on the same clock: the memory request for the last word below the protected region, and the automatic exit from the mode with the write latch cleared. The bench provokes this by opening a sequence two words below `PROT_BASE` and sending one continuation. It then reads status while the write is still busy and expects 0x01: busy set, with the latch and mode already gone. The request log must show that exact word. A further continuation must add nothing to the log.

// File: rtl/aai_seq_pkg.sv
package aai_seq_pkg;
  localparam logic [7:0] OP_AAI  = 8'hAD;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_EBSY = 8'h70;
  localparam logic [7:0] OP_DBSY = 8'h80;
  localparam int ST_BUSY = 0;
  localparam int ST_WEL  = 1;
  localparam int ST_AAI  = 6;
endpackage

// File: rtl/aai_sync2.sv
module aai_sync2 #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/aai_spi_rx.sv
module aai_spi_rx #(
  parameter int BW = 8,
  parameter int NB_W = 3,
  localparam int CW = $clog2(BW)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sck_i,
  input  logic            csn_i,
  input  logic            mosi_i,
  output logic            sel_o,
  output logic            sck_fall_o,
  output logic [CW-1:0]   bit_cnt_o,
  output logic            byte_vld_o,
  output logic [BW-1:0]   byte_o,
  output logic [NB_W-1:0] byte_idx_o,
  output logic [NB_W-1:0] nbytes_o,
  output logic            frame_end_o,
  output logic            frame_ok_o
);
  logic [2:0] pins_s;
  logic sck_s, csn_s, mosi_s, sck_q, csn_q, sck_rise;
  logic [BW-1:0] sh_q;
  localparam logic [NB_W-1:0] NB_MAX = '1;

  aai_sync2 #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({mosi_i, csn_i, sck_i}),
    .q_o   (pins_s)
  );
  assign sck_s  = pins_s[0];
  assign csn_s  = pins_s[1];
  assign mosi_s = pins_s[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      csn_q <= 1'b1;
    end else begin
      sck_q <= sck_s;
      csn_q <= csn_s;
    end
  end

  assign sel_o       = ~csn_s;
  assign sck_rise    = sck_s & ~sck_q & ~csn_s;
  assign sck_fall_o  = ~sck_s & sck_q & ~csn_s;
  assign frame_end_o = csn_s & ~csn_q;
  // complete bytes only: mid-byte select release aborts
  assign frame_ok_o  = (bit_cnt_o == '0) && (nbytes_o != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q       <= '0;
      bit_cnt_o  <= '0;
      nbytes_o   <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
      byte_idx_o <= '0;
    end else begin
      byte_vld_o <= 1'b0;
      if (csn_s) begin
        if (!frame_end_o) begin
          bit_cnt_o <= '0;
          nbytes_o  <= '0;
        end
      end else if (sck_rise) begin
        sh_q      <= {sh_q[BW-2:0], mosi_s};
        bit_cnt_o <= bit_cnt_o + 1'b1;
        if (bit_cnt_o == CW'(BW-1)) begin
          byte_vld_o <= 1'b1;
          byte_o     <= {sh_q[BW-2:0], mosi_s};
          byte_idx_o <= nbytes_o;
          if (nbytes_o != NB_MAX) nbytes_o <= nbytes_o + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/aai_busy_tmr.sv
module aai_busy_tmr #(
  parameter int BUSY_CYC = 40,
  localparam int TW = $clog2(BUSY_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  logic [TW-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= TW'(BUSY_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end
  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/aai_ctrl.sv
module aai_ctrl
  import aai_seq_pkg::*;
#(
  parameter int AW = 24,
  parameter int unsigned PROT_BASE = 4096,
  parameter int NB_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sel_i,
  input  logic            sck_fall_i,
  input  logic [2:0]      bit_cnt_i,
  input  logic            byte_vld_i,
  input  logic [7:0]      byte_i,
  input  logic [NB_W-1:0] byte_idx_i,
  input  logic [NB_W-1:0] nbytes_i,
  input  logic            frame_end_i,
  input  logic            frame_ok_i,
  input  logic            busy_i,
  output logic            prog_req_o,
  output logic [AW-1:0]   prog_addr_o,
  output logic [15:0]     prog_data_o,
  output logic            wel_o,
  output logic            aai_o,
  output logic            hw_o,
  output logic            so_o,
  output logic            so_oe_o
);
  localparam logic [AW+1:0] PB = (AW+2)'(PROT_BASE);

  logic [7:0]    op_q;
  logic [23:0]   addr_sh_q;
  logic [15:0]   d_sh_q;
  logic [AW-1:0] cur_q, start_addr, iss_addr;
  logic          rd_st_q, so_q;
  logic [6:0]    tx_q;
  logic [7:0]    status;
  logic act, is_aai, do_start, do_next, do_wrdi, do_wren, do_ebsy, do_dbsy, last, live;

  assign start_addr = {addr_sh_q[AW-1:1], 1'b0};
  assign iss_addr   = aai_o ? cur_q : start_addr;

  always_comb begin
    act      = frame_end_i & frame_ok_i & ~busy_i;
    is_aai   = (op_q == OP_AAI);
    do_start = act & is_aai & ~aai_o & wel_o & (nbytes_i == NB_W'(6)) &
               (({2'b0, start_addr} + 1'b1) < PB);
    do_next  = act & is_aai & aai_o & (nbytes_i == NB_W'(3));
    do_wrdi  = act & (op_q == OP_WRDI);
    do_wren  = act & (op_q == OP_WREN) & ~aai_o;
    do_ebsy  = act & (op_q == OP_EBSY) & ~aai_o;
    do_dbsy  = act & (op_q == OP_DBSY) & ~aai_o;
    // successor word would reach protected space
    last     = (({2'b0, iss_addr} + (AW+2)'(3)) >= PB);
    status   = '0;
    status[ST_BUSY] = busy_i;
    status[ST_WEL]  = wel_o;
    status[ST_AAI]  = aai_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q      <= '0;
      addr_sh_q <= '0;
      d_sh_q    <= '0;
    end else if (byte_vld_i) begin
      if (byte_idx_i == '0) op_q <= byte_i;
      else begin
        d_sh_q <= {d_sh_q[7:0], byte_i};
        if (byte_idx_i <= NB_W'(3)) addr_sh_q <= {addr_sh_q[15:0], byte_i};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_req_o  <= 1'b0;
      prog_addr_o <= '0;
      prog_data_o <= '0;
      cur_q       <= '0;
      wel_o       <= 1'b0;
      aai_o       <= 1'b0;
      hw_o        <= 1'b0;
    end else begin
      prog_req_o <= 1'b0;
      if (do_start | do_next) begin
        prog_req_o  <= 1'b1;
        prog_addr_o <= iss_addr;
        prog_data_o <= d_sh_q;
        cur_q       <= iss_addr + AW'(2);
        aai_o       <= ~last;
        if (last) wel_o <= 1'b0;
      end
      if (do_wrdi) begin
        wel_o <= 1'b0;
        aai_o <= 1'b0;
      end
      if (do_wren) wel_o <= 1'b1;
      if (do_ebsy) hw_o  <= 1'b1;
      if (do_dbsy) hw_o  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_st_q <= 1'b0;
      tx_q    <= '0;
      so_q    <= 1'b0;
    end else begin
      if (!sel_i) rd_st_q <= 1'b0;
      else if (byte_vld_i && byte_idx_i == '0)
        rd_st_q <= (byte_i == OP_RDSR) & ~(aai_o & hw_o);
      if (sck_fall_i && rd_st_q) begin
        if (bit_cnt_i == '0) begin
          so_q <= status[7];
          tx_q <= status[6:0];
        end else begin
          so_q <= tx_q[6];
          tx_q <= {tx_q[5:0], 1'b0};
        end
      end
    end
  end

  assign live    = sel_i & hw_o & (aai_o | busy_i);
  assign so_o    = live ? ~busy_i : so_q;
  assign so_oe_o = live | (sel_i & rd_st_q);
endmodule

// File: rtl/aai_word_seq.sv
module aai_word_seq #(
  parameter int AW = 24,
  parameter int unsigned PROT_BASE = 4096,
  parameter int BUSY_CYC = 40
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sck_i,
  input  logic          csn_i,
  input  logic          mosi_i,
  output logic          so_o,
  output logic          so_oe_o,
  output logic          prog_req_o,
  output logic [AW-1:0] prog_addr_o,
  output logic [15:0]   prog_data_o
);
  localparam int NB_W = 3;

  logic sel, sck_fall, byte_vld, frame_end, frame_ok, busy, wel, aai_on, hw_on;
  logic [2:0] bit_cnt;
  logic [7:0] rx_byte;
  logic [NB_W-1:0] byte_idx, nbytes;

  aai_spi_rx #(.BW(8), .NB_W(NB_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sck_i      (sck_i),
    .csn_i      (csn_i),
    .mosi_i     (mosi_i),
    .sel_o      (sel),
    .sck_fall_o (sck_fall),
    .bit_cnt_o  (bit_cnt),
    .byte_vld_o (byte_vld),
    .byte_o     (rx_byte),
    .byte_idx_o (byte_idx),
    .nbytes_o   (nbytes),
    .frame_end_o(frame_end),
    .frame_ok_o (frame_ok)
  );

  aai_ctrl #(.AW(AW), .PROT_BASE(PROT_BASE), .NB_W(NB_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel),
    .sck_fall_i (sck_fall),
    .bit_cnt_i  (bit_cnt),
    .byte_vld_i (byte_vld),
    .byte_i     (rx_byte),
    .byte_idx_i (byte_idx),
    .nbytes_i   (nbytes),
    .frame_end_i(frame_end),
    .frame_ok_i (frame_ok),
    .busy_i     (busy),
    .prog_req_o (prog_req_o),
    .prog_addr_o(prog_addr_o),
    .prog_data_o(prog_data_o),
    .wel_o      (wel),
    .aai_o      (aai_on),
    .hw_o       (hw_on),
    .so_o       (so_o),
    .so_oe_o    (so_oe_o)
  );

  aai_busy_tmr #(.BUSY_CYC(BUSY_CYC)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(prog_req_o),
    .busy_o (busy)
  );
endmodule

// File: rtl/aai_word_seq_chk.sv
module aai_word_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic prog_req_i,
  input logic addr_lsb_i,
  input logic busy_i,
  input logic wel_i,
  input logic aai_i,
  input logic hw_i,
  input logic sel_i,
  input logic so_i,
  input logic so_oe_i
);
  // R5
  busy_after_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_i |=> busy_i);
  // R5
  no_req_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_i |-> !busy_i);
  // R1
  even_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_i |-> !addr_lsb_i);
  // R3
  start_needs_wel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aai_i) |-> $past(wel_i));
  // R1
  start_issues_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aai_i) |-> prog_req_i);
  // R8
  exit_clears_wel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(aai_i) |-> !wel_i);
  // R6
  live_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_i && aai_i && sel_i) |-> (so_oe_i && (so_i == !busy_i)));
endmodule

bind aai_word_seq aai_word_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .prog_req_i(prog_req_o),
  .addr_lsb_i(prog_addr_o[0]),
  .busy_i    (busy),
  .wel_i     (wel),
  .aai_i     (aai_on),
  .hw_i      (hw_on),
  .sel_i     (sel),
  .so_i      (so_o),
  .so_oe_i   (so_oe_o)
);

// File: tb/sim_aai_word_seq.sv
module sim_aai_word_seq;
  localparam int AW = 24;
  localparam int PB = 4096;
  localparam int BUSY = 600;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic so, so_oe, req;
  logic [AW-1:0] paddr;
  logic [15:0] pdata;
  int n_tests = 0, n_fail = 0, n_req = 0;
  logic [AW-1:0] last_addr;
  logic [15:0] last_data;
  bit done = 0;

  always #2 clk = ~clk;

  aai_word_seq #(.AW(AW), .PROT_BASE(PB), .BUSY_CYC(BUSY)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .csn_i(csn), .mosi_i(mosi),
    .so_o(so), .so_oe_o(so_oe), .prog_req_o(req),
    .prog_addr_o(paddr), .prog_data_o(pdata)
  );

  always @(negedge clk) if (req) begin
    n_req++;
    last_addr = paddr;
    last_data = pdata;
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbegin();
    csn = 1'b0;
    clks(4);
  endtask

  task automatic send_end();
    clks(4);
    csn = 1'b1;
    clks(12);
  endtask

  task automatic bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      mosi = tx[i];
      clks(HALF);
      rx[i] = so;
      sck = 1'b1;
      clks(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] d;
    sbegin();
    bits(op, 8, d);
    send_end();
  endtask

  task automatic rd_status(output logic [7:0] st);
    logic [7:0] d;
    sbegin();
    bits(8'h05, 8, d);
    bits(8'h00, 8, st);
    send_end();
  endtask

  task automatic aai_first(input logic [23:0] a, input logic [7:0] d0, input logic [7:0] d1);
    logic [7:0] d;
    sbegin();
    bits(8'hAD, 8, d);
    bits(a[23:16], 8, d);
    bits(a[15:8], 8, d);
    bits(a[7:0], 8, d);
    bits(d0, 8, d);
    bits(d1, 8, d);
    send_end();
  endtask

  task automatic aai_next(input logic [7:0] d0, input logic [7:0] d1);
    logic [7:0] d;
    sbegin();
    bits(8'hAD, 8, d);
    bits(d0, 8, d);
    bits(d1, 8, d);
    send_end();
  endtask

  task automatic wait_idle();
    logic [7:0] st;
    for (int k = 0; k < 40; k++) begin
      rd_status(st);
      if (!st[0]) break;
    end
  endtask

  function automatic logic [7:0] exp_st(input bit busy, input bit wel, input bit aai);
    return {1'b0, aai, 4'b0, wel, busy};
  endfunction

  initial begin : main
    logic [7:0] st, st2, d, b0, b1;
    logic [23:0] ea;
    int n0, nw;
    void'($urandom(32'h5EED1));
    clks(5);
    rst_n = 1'b1;
    clks(5);
    // R12 reset state
    chk("R12 so_oe", so_oe, 0);
    rd_status(st);
    chk("R12 status", st, 8'h00);
    chk("R12 no req", n_req, 0);

    // R3 start without write latch
    aai_first(24'h000100, 8'h12, 8'h34);
    chk("R3 no req", n_req, 0);
    rd_status(st);
    chk("R3 status", st, 8'h00);

    // R10 aborted write enable
    sbegin(); bits(8'h06, 5, d); send_end();
    rd_status(st);
    chk("R10 abort", st, 8'h00);

    // R4 write enable, R11 format
    cmd(8'h06);
    rd_status(st);
    chk("R4 wel set", st, exp_st(0, 1, 0));

    // R9 protected start
    aai_first(24'(PB + 16), 8'h01, 8'h02);
    chk("R9 no req", n_req, 0);
    rd_status(st);
    chk("R9 status", st, exp_st(0, 1, 0));

    // R1 first entry with odd address
    aai_first(24'h000101, 8'hA5, 8'h3C);
    chk("R1 req count", n_req, 1);
    chk("R1 addr", last_addr, 24'h000100);
    chk("R1 data", last_data, 16'hA53C);
    // R11 continuous status during busy, R5 busy
    sbegin();
    bits(8'h05, 8, d);
    bits(8'h00, 8, st);
    bits(8'h00, 8, st2);
    send_end();
    chk("R11 status byte1", st, exp_st(1, 1, 1));
    chk("R11 status byte2", st2, exp_st(1, 1, 1));
    wait_idle();

    // R2 next entry, R5 write disable dropped while busy
    aai_next(8'h11, 8'h22);
    chk("R2 addr", last_addr, 24'h000102);
    chk("R2 data", last_data, 16'h1122);
    cmd(8'h04);
    wait_idle();
    rd_status(st);
    chk("R5 dropped while busy", st, exp_st(0, 1, 1));

    // R7 busy-output enable ignored in software mode
    cmd(8'h70);
    ea = 24'h000104;
    nw = 5 + ($urandom % 6);
    for (int w = 0; w < nw; w++) begin
      b0 = 8'($urandom);
      b1 = 8'($urandom);
      n0 = n_req;
      aai_next(b0, b1);
      if (w == 0) begin
        sbegin();
        chk("R7 no live busy", so_oe, 0);
        send_end();
      end
      chk("R2 rand count", n_req, n0 + 1);
      chk("R2 rand addr", last_addr, ea);
      chk("R2 rand data", last_data, {b0, b1});
      ea = ea + 24'd2;
      wait_idle();
    end

    // R4 write disable exits
    cmd(8'h04);
    rd_status(st);
    chk("R4 exit", st, 8'h00);

    // R6 hardware busy output
    cmd(8'h70);
    cmd(8'h06);
    aai_first(24'h000200, 8'h55, 8'hAA);
    sbegin(); clks(6);
    chk("R6 oe busy", so_oe, 1);
    chk("R6 so busy", so, 0);
    send_end();
    clks(2);
    chk("R6 released", so_oe, 0);
    clks(BUSY + 50);
    sbegin(); clks(6);
    chk("R6 so ready", so, 1);
    send_end();

    // R7 hardware mode ignores 0x80
    cmd(8'h80);
    n0 = n_req;
    aai_next(8'h66, 8'h77);
    chk("R7 hw accept AD", n_req, n0 + 1);
    chk("R2 hw addr", last_addr, 24'h000202);
    sbegin(); clks(6);
    chk("R7 hw still live", so_oe, 1);
    chk("R7 so busy", so, 0);
    send_end();
    clks(BUSY + 50);
    cmd(8'h04);
    cmd(8'h80);
    rd_status(st);
    chk("R6 after exit status", st, 8'h00);

    // R8 top of unprotected range
    cmd(8'h06);
    aai_first(24'(PB - 4), 8'hC1, 8'hC2);
    wait_idle();
    n0 = n_req;
    aai_next(8'hD1, 8'hD2);
    chk("R8 last req", n_req, n0 + 1);
    chk("R8 last addr", last_addr, 24'(PB - 2));
    rd_status(st);
    chk("R8 exit while busy", st, exp_st(1, 0, 0));
    wait_idle();
    aai_next(8'hE1, 8'hE2);
    chk("R8 no wrap", n_req, n0 + 1);
    rd_status(st);
    chk("R8 status", st, 8'h00);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule